// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front End

This block is the device side of a three-wire serial EEPROM. It collects instructions sent by a host on a select line, a serial clock and a serial data line. It decodes the start bit, the opcode, the address and any write data, and passes each finished command to a program sequencer. Read instructions are served directly: the block fetches words from the storage array through a synchronous read port and shifts them out, one bit per serial clock. After a write-type command, the output line reports whether the sequencer is still busy. At all other times the output is released.

A mode input selects 16-bit words with a 10-bit address, or 8-bit words with an 11-bit address. The serial pins are sampled with the block's system clock. The inputs must be synchronous to that clock, and each serial clock level must be held for at least three system clock cycles. An output change appears two to three system clock cycles after the serial edge that causes it. The output data and its enable are separate ports. The pad logic builds the high-impedance state from them.

Top module: `mw_eeprom_if`

## Requirements
- R1: After reset, `ser_out_en`, `cmd_valid` and `arr_rd_en` are all low.
- R2: Data is sampled on rising `ser_clk` edges while `ser_sel` is high. Zeros before the first 1 are ignored. That 1 is the start bit, and the next two bits are the opcode: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 special.
- R3: The address follows the opcode, MSB first. It is 10 bits when `word16_mode` is 1 and 11 bits when it is 0. Write data follows the address, MSB first. It is 16 bits in 16-bit mode and 8 bits in 8-bit mode, and is placed in the low bits of `cmd_data`.
- R4: For the special opcode, the two most significant address bits pick the command: 2'b11 write enable, 2'b00 write disable, 2'b10 clear all, 2'b01 write all. Only write all is followed by a data field.
- R5: A command is issued as a one-cycle `cmd_valid` pulse after `ser_sel` falls, and only if the instruction was received completely. The `cmd_op` codes are: 1 write, 2 erase, 3 clear all, 4 write all, 5 write enable, 6 write disable. Bits that arrive after a complete instruction are ignored. A partial instruction issues nothing.
- R6: When the last address bit of a read arrives, `ser_out_en` rises with `ser_out` low for one dummy bit. Each following rising edge presents the next bit of the addressed word, MSB first. In 8-bit mode the word is the low 8 bits of `arr_rd_data`.
- R7: While `ser_sel` stays high, reading continues with the next address and no dummy bit. The address wraps from 1023 (16-bit mode) or 2047 (8-bit mode) to 0.
- R8: `arr_rd_data` is taken one cycle after `arr_rd_en`, for the address on `arr_rd_addr`.
- R9: After a write, erase, clear-all or write-all command is issued, `ser_out_en` is high whenever `ser_sel` is high, and `ser_out` shows the inverse of `seq_busy`. Write enable and write disable do not cause this.
- R10: A 1 sampled while the status is shown turns `ser_out_en` off at the next falling `ser_clk` edge. That same 1 also serves as the start bit of the next instruction.
- R11: While `ser_sel` is low, `ser_out_en` is low and any partial instruction is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word16_mode | input | 1 | 1: 16-bit words, 0: 8-bit words |
| ser_sel | input | 1 | Serial select, active high |
| ser_clk | input | 1 | Serial clock |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out |
| ser_out_en | output | 1 | Output drive enable |
| seq_busy | input | 1 | Program sequencer busy |
| cmd_valid | output | 1 | Command pulse |
| cmd_op | output | 3 | Command code |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | WORD_W | Command write data |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | WORD_W | Array read data, one cycle after strobe |

## Verification
Reads are tried with leading zeros, at a mid-range address, and at the top address of each word mode. Comparing the bit stream against an address-dependent pattern separates a missing or repeated dummy bit, a wrong increment and a wrong wrap point. Each of the four special selectors, in both modes, exposes swapped field positions or a wrong data-field length. Aborted instructions, trailing extra bits and the status release sequence separate issuing on select fall from issuing on the last bit, and release on the falling edge from release on the rising edge.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the serial EEPROM front end.
package mw_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_ERASE    = 3'd2,
        OP_CLR_ALL  = 3'd3,
        OP_FILL_ALL = 3'd4,
        OP_WR_EN    = 3'd5,
        OP_WR_DIS   = 3'd6
    } mw_op_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_OPC, RX_ADDR, RX_DATA, RX_HOLD, RX_READ
    } mw_rx_e;

    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_ERASE   = 2'b11;
    localparam logic [1:0] OPC_SPECIAL = 2'b00;

    localparam logic [1:0] SEL_WR_EN   = 2'b11;
    localparam logic [1:0] SEL_WR_DIS  = 2'b00;
    localparam logic [1:0] SEL_CLR     = 2'b10;
    localparam logic [1:0] SEL_FILL    = 2'b01;
endpackage

// File: rtl/mw_pin_sync.sv
`timescale 1ns/1ps
// Registers the serial pins once and derives serial clock edge strobes.
// Assumes the pins are synchronous to clk and each serial clock level
// lasts at least three clk cycles.
module mw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_sel,
    input  logic ser_clk,
    input  logic ser_in,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise,
    output logic sk_fall
);
    logic sk_s;
    logic sk_d;

    // Sample the pins and keep the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s <= 1'b0;
            sk_s <= 1'b0;
            di_s <= 1'b0;
            sk_d <= 1'b0;
        end else begin
            cs_s <= ser_sel;
            sk_s <= ser_clk;
            di_s <= ser_in;
            sk_d <= sk_s;
        end
    end

    // Edge strobes count only while selected.
    always_comb begin
        sk_rise = cs_s & sk_s & ~sk_d;
        sk_fall = cs_s & ~sk_s & sk_d;
    end
endmodule

// File: rtl/mw_cmd_rx.sv
`timescale 1ns/1ps
// Instruction receiver: start bit hunt, opcode, address and data shift.
// Issues finished non-read commands when select drops. Starts reads
// when the last address bit arrives. Assumes a single-cycle sk_rise strobe.
module mw_cmd_rx
    import mw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              cs_s,
    input  logic              di_s,
    input  logic              sk_rise,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_start_addr,
    output logic              cmd_valid,
    output mw_op_e            cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [WORD_W-1:0] cmd_data
);
    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [ADDR_W-1:0] MASK_WIDE = {1'b0, {(ADDR_W-1){1'b1}}};

    mw_rx_e            state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  aw_last;
    logic [CNT_W-1:0]  dw_last;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nx;
    logic [WORD_W-1:0] data_q;
    logic [1:0]        sel_nx;
    logic [1:0]        sel_q;

    // Field lengths and selector position follow the word mode.
    always_comb begin
        aw_last = wide ? CNT_W'(ADDR_W-2) : CNT_W'(ADDR_W-1);
        dw_last = wide ? CNT_W'(WORD_W-1) : CNT_W'(WORD_W/2-1);
        addr_nx = {addr_q[ADDR_W-2:0], di_s};
        sel_nx  = wide ? addr_nx[ADDR_W-2:ADDR_W-3] : addr_nx[ADDR_W-1:ADDR_W-2];
        sel_q   = wide ? addr_q[ADDR_W-2:ADDR_W-3]  : addr_q[ADDR_W-1:ADDR_W-2];
    end

    // Receive state machine, advanced on each sampled rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= RX_IDLE;
            cnt           <= '0;
            op_q          <= '0;
            addr_q        <= '0;
            data_q        <= '0;
            rd_start      <= 1'b0;
            rd_start_addr <= '0;
            cmd_valid     <= 1'b0;
        end else begin
            rd_start  <= 1'b0;
            cmd_valid <= 1'b0;
            if (!cs_s) begin
                cmd_valid <= (state == RX_HOLD);
                state     <= RX_IDLE;
                cnt       <= '0;
            end else if (sk_rise) begin
                case (state)
                    RX_IDLE: begin
                        if (di_s) begin
                            state  <= RX_OPC;
                            cnt    <= '0;
                            addr_q <= '0;
                            data_q <= '0;
                        end
                    end
                    RX_OPC: begin
                        op_q <= {op_q[0], di_s};
                        if (cnt == CNT_W'(1)) begin
                            state <= RX_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_ADDR: begin
                        addr_q <= addr_nx;
                        if (cnt == aw_last) begin
                            cnt <= '0;
                            if (op_q == OPC_READ) begin
                                state         <= RX_READ;
                                rd_start      <= 1'b1;
                                rd_start_addr <= wide ? (addr_nx & MASK_WIDE) : addr_nx;
                            end else if (op_q == OPC_WRITE ||
                                         (op_q == OPC_SPECIAL && sel_nx == SEL_FILL)) begin
                                state <= RX_DATA;
                            end else begin
                                state <= RX_HOLD;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_DATA: begin
                        data_q <= {data_q[WORD_W-2:0], di_s};
                        if (cnt == dw_last) begin
                            state <= RX_HOLD;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Command code from the stored opcode and selector bits.
    always_comb begin
        case (op_q)
            OPC_WRITE: cmd_op = OP_WRITE;
            OPC_ERASE: cmd_op = OP_ERASE;
            OPC_SPECIAL: begin
                case (sel_q)
                    SEL_WR_EN:  cmd_op = OP_WR_EN;
                    SEL_WR_DIS: cmd_op = OP_WR_DIS;
                    SEL_CLR:    cmd_op = OP_CLR_ALL;
                    default:    cmd_op = OP_FILL_ALL;
                endcase
            end
            default: cmd_op = OP_NONE;
        endcase
    end

    assign cmd_addr = addr_q;
    assign cmd_data = data_q;

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r6_read_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> $past(state == RX_ADDR));
    a_r11_no_cmd_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, rd_start}));
endmodule

// File: rtl/mw_read_out.sv
`timescale 1ns/1ps
// Read streamer: sends the dummy zero, then the words MSB first, with
// address increment and wrap. Fetches the next word right after the last
// bit of the current one is sent. Assumes rd_data arrives one cycle after rd_en.
module mw_read_out #(
    parameter int ADDR_W = 11,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              cs_s,
    input  logic              sk_rise,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_start_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              active,
    output logic              dout
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int HALF_W = WORD_W / 2;
    localparam logic [ADDR_W-1:0] MASK_WIDE = {1'b0, {(ADDR_W-1){1'b1}}};

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_inc;
    logic [WORD_W-1:0] word_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BIT_W-1:0]  bit_last;
    logic              fetch_d;

    // Next address with a mode-dependent wrap.
    always_comb begin
        addr_inc = (addr_q + ADDR_W'(1)) & (wide ? MASK_WIDE : {ADDR_W{1'b1}});
        bit_last = wide ? BIT_W'(WORD_W-1) : BIT_W'(HALF_W-1);
    end

    // Output sequencing and array fetch requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            dout    <= 1'b0;
            addr_q  <= '0;
            bit_q   <= '0;
            rd_en   <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_en <= 1'b0;
            if (!cs_s) begin
                active <= 1'b0;
                dout   <= 1'b0;
            end else if (rd_start) begin
                active  <= 1'b1;
                dout    <= 1'b0;
                addr_q  <= rd_start_addr;
                rd_en   <= 1'b1;
                rd_addr <= rd_start_addr;
                bit_q   <= bit_last;
            end else if (active && sk_rise) begin
                dout <= word_q[bit_q];
                if (bit_q == '0) begin
                    addr_q  <= addr_inc;
                    rd_en   <= 1'b1;
                    rd_addr <= addr_inc;
                    bit_q   <= bit_last;
                end else begin
                    bit_q <= bit_q - BIT_W'(1);
                end
            end
        end
    end

    // Capture the fetched word one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_d <= 1'b0;
            word_q  <= '0;
        end else begin
            fetch_d <= rd_en;
            if (fetch_d) begin
                word_q <= wide ? rd_data : {{(WORD_W-HALF_W){1'b0}}, rd_data[HALF_W-1:0]};
            end
        end
    end

    a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wide) |-> !rd_addr[ADDR_W-1]);
    a_r6_bit_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_q <= bit_last));
endmodule

// File: rtl/mw_status.sv
`timescale 1ns/1ps
// Ready/busy status tracker. Arms when a write-type command is issued and
// shows status while selected. Releases at the falling serial edge after a
// 1 is sampled. Assumes cmd_valid only pulses while deselected.
module mw_status
    import mw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_s,
    input  logic   di_s,
    input  logic   sk_rise,
    input  logic   sk_fall,
    input  logic   cmd_valid,
    input  mw_op_e cmd_op,
    output logic   st_oe
);
    logic armed;
    logic rel;
    logic wr_type;

    // Commands that start a program cycle.
    always_comb begin
        wr_type = (cmd_op == OP_WRITE) || (cmd_op == OP_ERASE) ||
                  (cmd_op == OP_CLR_ALL) || (cmd_op == OP_FILL_ALL);
    end

    // Arm, request release, release on the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            rel   <= 1'b0;
        end else if (cmd_valid && wr_type) begin
            armed <= 1'b1;
            rel   <= 1'b0;
        end else if (!cs_s) begin
            rel <= 1'b0;
        end else if (rel && sk_fall) begin
            armed <= 1'b0;
            rel   <= 1'b0;
        end else if (armed && sk_rise && di_s) begin
            rel <= 1'b1;
        end
    end

    assign st_oe = armed & cs_s;

    a_r10_release_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> $past(rel));
endmodule

// File: rtl/mw_eeprom_if.sv
`timescale 1ns/1ps
// Top of the serial EEPROM front end: pin sampling, instruction receiver,
// read streamer and status tracker, with the output mux. Assumes the
// pins are synchronous to clk and the serial clock is at least 6x slower.
module mw_eeprom_if
    import mw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word16_mode,
    input  logic              ser_sel,
    input  logic              ser_clk,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_out_en,
    input  logic              seq_busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [WORD_W-1:0] cmd_data,
    output logic              arr_rd_en,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [WORD_W-1:0] arr_rd_data
);
    logic              cs_s;
    logic              di_s;
    logic              sk_rise;
    logic              sk_fall;
    logic              rd_start;
    logic [ADDR_W-1:0] rd_start_addr;
    mw_op_e            op_dec;
    logic              ro_active;
    logic              ro_dout;
    logic              st_oe;

    mw_pin_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_sel (ser_sel),
        .ser_clk (ser_clk),
        .ser_in  (ser_in),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .sk_rise (sk_rise),
        .sk_fall (sk_fall)
    );

    mw_cmd_rx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .wide          (word16_mode),
        .cs_s          (cs_s),
        .di_s          (di_s),
        .sk_rise       (sk_rise),
        .rd_start      (rd_start),
        .rd_start_addr (rd_start_addr),
        .cmd_valid     (cmd_valid),
        .cmd_op        (op_dec),
        .cmd_addr      (cmd_addr),
        .cmd_data      (cmd_data)
    );

    mw_read_out #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .wide          (word16_mode),
        .cs_s          (cs_s),
        .sk_rise       (sk_rise),
        .rd_start      (rd_start),
        .rd_start_addr (rd_start_addr),
        .rd_en         (arr_rd_en),
        .rd_addr       (arr_rd_addr),
        .rd_data       (arr_rd_data),
        .active        (ro_active),
        .dout          (ro_dout)
    );

    mw_status u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .di_s      (di_s),
        .sk_rise   (sk_rise),
        .sk_fall   (sk_fall),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_dec),
        .st_oe     (st_oe)
    );

    // Output mux: read data has priority over status.
    always_comb begin
        cmd_op     = op_dec;
        ser_out_en = ro_active | st_oe;
        ser_out    = ro_active ? ro_dout : (st_oe & ~seq_busy);
    end

    a_r11_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ser_sel) && $past(!ser_sel, 2) && $past(!ser_sel, 3)) |-> !ser_out_en);
endmodule

// File: tb/mw_eeprom_if_tb.sv
`timescale 1ns/1ps
module mw_eeprom_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word16_mode = 1'b1;
    logic        ser_sel = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic        ser_out_en;
    logic        seq_busy = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [10:0] cmd_addr;
    logic [15:0] cmd_data;
    logic        arr_rd_en;
    logic [10:0] arr_rd_addr;
    logic [15:0] arr_rd_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int n_cmd = 0;
    logic [2:0]  last_op;
    logic [10:0] last_addr;
    logic [15:0] last_data;

    always #5 clk = ~clk;

    mw_eeprom_if u_dut (
        .clk(clk), .rst_n(rst_n), .word16_mode(word16_mode),
        .ser_sel(ser_sel), .ser_clk(ser_clk), .ser_in(ser_in),
        .ser_out(ser_out), .ser_out_en(ser_out_en), .seq_busy(seq_busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
        .arr_rd_data(arr_rd_data)
    );

    // Array contents as a function of the address.
    function automatic logic [15:0] mem_f(input logic [10:0] a);
        return (16'(a) * 16'd40503) ^ 16'h5A5A;
    endfunction

    // Synchronous array model.
    always @(posedge clk) arr_rd_data <= mem_f(arr_rd_addr);

    // Command log, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            n_cmd     = n_cmd + 1;
            last_op   = cmd_op;
            last_addr = cmd_addr;
            last_data = cmd_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic phase(input logic lvl);
        ser_clk = lvl;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic bit_out(input logic b);
        ser_in = b;
        phase(1'b0);
        phase(1'b1);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic select();
        ser_in = 1'b0;
        ser_sel = 1'b1;
        phase(1'b0);
    endtask

    task automatic deselect();
        ser_sel = 1'b0;
        ser_clk = 1'b0;
        repeat (6) @(posedge clk);
        #1;
    endtask

    // Expected stream: the word MSB first, one bit per rising edge.
    task automatic expect_word(input string tag, input logic [15:0] w, input int width);
        for (int i = width - 1; i >= 0; i--) begin
            bit_out(1'b0);
            chk(tag, {ser_out_en, ser_out}, {1'b1, w[i]});
        end
    endtask

    task automatic expect_cmd(input string tag, input int base, input logic [2:0] op,
                              input logic [10:0] a, input logic [15:0] d, input bit use_ad);
        chk({tag, " count"}, n_cmd, base + 1);
        chk({tag, " op"}, last_op, op);
        if (use_ad) begin
            chk({tag, " addr"}, last_addr, a);
            chk({tag, " data"}, last_data, d);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int base;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 oe", ser_out_en, 0);
        chk("R1 rd_en", arr_rd_en, 0);
        chk("R1 no cmd", n_cmd, 0);

        // R2 leading zeros, R6 dummy bit and first word, R7 next word
        select();
        send(32'b00110, 5);
        send(32'd5, 10);
        chk("R6 dummy", {ser_out_en, ser_out}, 2'b10);
        expect_word("R6 word5", mem_f(11'd5), 16);
        expect_word("R7 word6", mem_f(11'd6), 16);
        deselect();
        chk("R11 released", ser_out_en, 0);
        chk("R2 read issues no cmd", n_cmd, 0);

        // R7 wrap in 16-bit mode
        select();
        send(32'b110, 3);
        send(32'h3FF, 10);
        chk("R6 dummy top", {ser_out_en, ser_out}, 2'b10);
        expect_word("R7 word1023", mem_f(11'd1023), 16);
        expect_word("R7 wrap16", mem_f(11'd0), 16);
        deselect();

        // R3 8-bit read with 11-bit address, R7 wrap at 2047
        word16_mode = 1'b0;
        select();
        send(32'b110, 3);
        send(32'h7FF, 11);
        chk("R3 dummy x8", {ser_out_en, ser_out}, 2'b10);
        expect_word("R3 word2047", {8'h00, mem_f(11'd2047) & 16'h00FF}, 8);
        expect_word("R7 wrap8", {8'h00, mem_f(11'd0) & 16'h00FF}, 8);
        deselect();
        word16_mode = 1'b1;

        // R3 R5 write in 16-bit mode
        base = n_cmd;
        select();
        send(32'b101, 3);
        send(32'h2A5, 10);
        send(32'hBEEF, 16);
        chk("R5 no status before issue", ser_out_en, 0);
        chk("R5 no early cmd", n_cmd, base);
        deselect();
        expect_cmd("R5 write", base, 3'd1, 11'h2A5, 16'hBEEF, 1);

        // R9 status busy/ready, R10 release and start bit reuse
        seq_busy = 1'b1;
        select();
        chk("R9 busy", {ser_out_en, ser_out}, 2'b10);
        seq_busy = 1'b0;
        phase(1'b0);
        chk("R9 ready", {ser_out_en, ser_out}, 2'b11);
        ser_in = 1'b1;
        phase(1'b1);
        chk("R10 held until fall", ser_out_en, 1);
        ser_in = 1'b1;
        phase(1'b0);
        chk("R10 released on fall", ser_out_en, 0);
        phase(1'b1);
        bit_out(1'b1);
        send(32'h155, 10);
        base = n_cmd;
        deselect();
        expect_cmd("R10 erase after release", base, 3'd2, 11'h155, 16'h0000, 0);
        chk("R10 erase addr", last_addr, 11'h155);

        // R4 special commands in 16-bit mode
        base = n_cmd;
        select();
        send(32'b100, 3);
        send({22'd0, 2'b11, 8'hA5}, 10);
        deselect();
        expect_cmd("R4 write enable", base, 3'd5, 0, 0, 0);
        select();
        chk("R9 enable does not arm", ser_out_en, 0);
        deselect();
        base = n_cmd;
        select();
        send(32'b100, 3);
        send({22'd0, 2'b00, 8'h3C}, 10);
        deselect();
        expect_cmd("R4 write disable", base, 3'd6, 0, 0, 0);
        base = n_cmd;
        select();
        send(32'b100, 3);
        send({22'd0, 2'b10, 8'h0F}, 10);
        deselect();
        expect_cmd("R4 clear all", base, 3'd3, 0, 0, 0);
        base = n_cmd;
        select();
        send(32'b100, 3);
        send({22'd0, 2'b01, 8'h00}, 10);
        send(32'h1234, 16);
        deselect();
        expect_cmd("R4 write all", base, 3'd4, 0, 0, 0);
        chk("R4 write all data", last_data, 16'h1234);

        // R11 R5 aborted instruction
        base = n_cmd;
        select();
        send(32'b101, 3);
        send(32'b10110, 5);
        deselect();
        chk("R11 abort issues nothing", n_cmd, base);

        // R5 extra bits after a complete instruction
        base = n_cmd;
        select();
        send(32'b111, 3);
        send(32'h001, 10);
        send(32'b101, 3);
        deselect();
        expect_cmd("R5 extra bits", base, 3'd2, 11'h001, 16'h0000, 0);
        chk("R5 extra bits addr", last_addr, 11'h001);

        // R3 R4 8-bit mode commands
        word16_mode = 1'b0;
        base = n_cmd;
        select();
        send(32'b101, 3);
        send(32'h5A3, 11);
        send(32'hC7, 8);
        deselect();
        expect_cmd("R3 write x8", base, 3'd1, 11'h5A3, 16'h00C7, 1);
        base = n_cmd;
        select();
        send(32'b100, 3);
        send({21'd0, 2'b10, 9'h0AB}, 11);
        deselect();
        expect_cmd("R4 clear all x8", base, 3'd3, 0, 0, 0);
        base = n_cmd;
        select();
        send(32'b100, 3);
        send({21'd0, 2'b01, 9'h000}, 11);
        send(32'h3E, 8);
        deselect();
        expect_cmd("R4 write all x8", base, 3'd4, 0, 0, 0);
        chk("R3 write all x8 data", last_data, 16'h003E);
        // R8 strobe idle once deselected
        chk("R8 rd_en idle", arr_rd_en, 0);

        summary();
    end
endmodule